// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a down-counting interval timer. Software reaches it through four 32-bit registers on a word-indexed bus that always completes in one cycle. Once the timer is both powered and enabled, a prescaler divides the clock by (scale + 1). Each prescaled tick takes one off the count register.

When a decrement brings the count to zero, the block pulses `irq` for one cycle and sets a sticky expiry flag that software reads in the control word. With reload selected, the next tick after zero loads the count from the period register and the timer keeps running. Without reload, the count stays at zero. Writing zero to the control word stops the timer.

Register accesses carry no handshake and never stall. A write on `bus_we` takes effect at the next clock edge. `bus_rdata` always shows the register that `bus_addr` selects. The block holds no data stream, so it has no valid/ready pair.

Top module: `intv_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: `bus_addr` is a word index. Index 0 (byte offset 0x0) is control, 1 (0x4) is period, 2 (0x8) is scale and 3 (0xC) is count. Values written to period, scale and count read back unchanged while the timer is powered but not enabled.
- R3: In the control word, bit 0 is power, bit 1 is enable, bit 2 is reload and bit 3 is the expiry flag. Bits above 3 always read 0.
- R4: The count holds unless power and enable are both 1.
- R5: The count decrements once every (scale + 1) cycles. The first decrement comes scale + 1 cycles after the write that starts counting, because the prescaler restarts each time counting starts.
- R6: With reload off, the count stays at 0 after expiry and control reads 0xB.
- R7: Each decrement from 1 to 0 gives exactly one one-cycle `irq` pulse. The expiry flag reads 1 from that same cycle onward.
- R8: With reload on, the tick after the count reaches 0 loads the period value. The period register keeps its value, control reads 0xF, and expiries repeat.
- R9: Writing control with bit 3 at 0 clears the expiry flag. Writing bit 3 as 1 never sets the flag.
- R10: Writing 0 to control stops counting, and the count then holds.
- R11: A bus write to count in a cycle that also has a tick stores the written value, not a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the block with its default 32-bit data width. It programs scale values of 0 and 2. Scale 0 puts a tick in every active cycle, so a bus write to count always collides with a decrement, and expiry and reload can be timed to the exact cycle. Scale 2 brings the divider spacing, and the restart of the prescaler after a pause, within reach of cycle-exact checks.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_SCALE  = 2'd2,
    SEL_COUNT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic flag;
    logic reload;
    logic enable;
    logic power;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [DATA_W-1:0] scale,
  output logic              tick
);
  logic [DATA_W-1:0] div_q;

  assign tick = active && (div_q >= scale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!active || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R5: with a nonzero scale, ticks are never back to back
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (scale == '0) || !tick);
endmodule

// File: rtl/intv_downcount.sv
module intv_downcount #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reload,
  input  logic [DATA_W-1:0] period,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] count,
  output logic              expire,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assign expire = tick && !load_en && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= expire;
      if (load_en) begin
        count <= load_val;
      end else if (tick) begin
        if (count != '0) begin
          count <= count - ONE;
        end else if (reload) begin
          count <= period;
        end
      end
    end
  end

  // R7: an expiry pulse only appears with the count at zero
  p_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0));

  // R7: the pulse lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 expire,
  input  logic [DATA_W-1:0]    count,
  output ctrl_t                ctrl,
  output logic [DATA_W-1:0]    period,
  output logic [DATA_W-1:0]    scale,
  output logic                 count_wr,
  output logic [DATA_W-1:0]    rdata
);
  localparam int PAD_W = DATA_W - CTRL_W;

  reg_sel_e sel;
  logic     ctrl_wr, period_wr, scale_wr;

  assign sel       = reg_sel_e'(addr);
  assign ctrl_wr   = we && (sel == SEL_CTRL);
  assign period_wr = we && (sel == SEL_PERIOD);
  assign scale_wr  = we && (sel == SEL_SCALE);
  assign count_wr  = we && (sel == SEL_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.power  <= wdata[0];
        ctrl.enable <= wdata[1];
        ctrl.reload <= wdata[2];
      end
      if (expire) begin
        ctrl.flag <= 1'b1;
      end else if (ctrl_wr && !wdata[3]) begin
        ctrl.flag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      scale  <= '0;
    end else begin
      if (period_wr) period <= wdata;
      if (scale_wr)  scale  <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rdata = {{PAD_W{1'b0}}, ctrl};
      SEL_PERIOD: rdata = period;
      SEL_SCALE:  rdata = scale;
      default:    rdata = count;
    endcase
  end

  // R8: period changes only through its own bus write
  p_period_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wr |=> $stable(period));
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] period, scale, count;
  logic              count_wr, expire, tick, active;

  assign active = ctrl.power && ctrl.enable;

  intv_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .expire   (expire),
    .count    (count),
    .ctrl     (ctrl),
    .period   (period),
    .scale    (scale),
    .count_wr (count_wr),
    .rdata    (bus_rdata)
  );

  intv_prescaler #(.DATA_W(DATA_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .scale  (scale),
    .tick   (tick)
  );

  intv_downcount #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reload   (ctrl.reload),
    .period   (period),
    .load_en  (count_wr),
    .load_val (bus_wdata),
    .count    (count),
    .expire   (expire),
    .irq      (irq)
  );

  // R4: the count holds while the timer is not both powered and enabled
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !count_wr) |=> $stable(count));

  // R7: the flag is visible in the cycle the pulse is
  p_flag_on_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl.flag);
endmodule

// File: tb/tb_intv_timer.sv
module tb_intv_timer;
  localparam int DW = 32;
  localparam logic [1:0] A_CTRL = 2'd0, A_PER = 2'd1, A_SCL = 2'd2, A_CNT = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0, fails = 0, irq_hits = 0, cycles = 0;
  bit done = 0;

  intv_timer #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (irq) irq_hits++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      check("R1 register reset", v, 0);
    end
    check("R1 irq reset", {31'd0, irq}, 0);
  endtask

  task automatic t_map;
    logic [DW-1:0] v;
    wr(A_CTRL, 1); wr(A_PER, 32'h20); wr(A_CNT, 2); wr(A_SCL, 5);
    rd(A_PER, v); check("R2 period readback", v, 32'h20);
    rd(A_CNT, v); check("R2 count readback", v, 2);
    rd(A_SCL, v); check("R2 scale readback", v, 5);
    wr(A_CTRL, 32'hFFFF_FFF7);
    rd(A_CTRL, v); check("R3 control bits", v, 7);
    wr(A_CTRL, 0);
  endtask

  task automatic t_oneshot;
    logic [DW-1:0] v;
    wr(A_CTRL, 1); wr(A_PER, 32'h20); wr(A_CNT, 2); wr(A_SCL, 0);
    irq_hits = 0;
    wr(A_CTRL, 3);
    rd(A_CNT, v); check("R6 count start", v, 2);
    step(1); rd(A_CNT, v); check("R6 count first tick", v, 1);
    check("R7 no early irq", {31'd0, irq}, 0);
    step(1); rd(A_CNT, v); check("R6 count zero", v, 0);
    check("R7 irq on zero", {31'd0, irq}, 1);
    rd(A_CTRL, v); check("R7 flag with irq", v, 32'hB);
    step(1); check("R7 irq one cycle", {31'd0, irq}, 0);
    step(5); rd(A_CNT, v); check("R6 count holds zero", v, 0);
    rd(A_CTRL, v); check("R6 control 0xB", v, 32'hB);
    check("R7 single pulse", irq_hits, 1);
    wr(A_CTRL, 32'hB); rd(A_CTRL, v); check("R9 bit3=1 keeps flag", v, 32'hB);
    wr(A_CTRL, 32'h3); rd(A_CTRL, v); check("R9 bit3=0 clears flag", v, 32'h3);
    wr(A_CTRL, 0);
    wr(A_CTRL, 32'h8); rd(A_CTRL, v); check("R9 bit3=1 does not set", v, 0);
  endtask

  task automatic t_reload;
    logic [DW-1:0] v;
    wr(A_CTRL, 1); wr(A_PER, 4); wr(A_CNT, 1); wr(A_SCL, 0);
    irq_hits = 0;
    wr(A_CTRL, 7);
    step(1); rd(A_CNT, v); check("R8 count zero", v, 0);
    rd(A_CTRL, v); check("R8 control 0xF", v, 32'hF);
    step(1); rd(A_CNT, v); check("R8 reload from period", v, 4);
    step(1); rd(A_CNT, v); check("R8 count after reload", v, 3);
    step(3); rd(A_CNT, v); check("R8 second zero", v, 0);
    check("R7 second irq", {31'd0, irq}, 1);
    step(1); rd(A_CNT, v); check("R8 second reload", v, 4);
    check("R8 expiry count", irq_hits, 2);
    rd(A_PER, v); check("R8 period kept", v, 4);
    wr(A_CTRL, 0);
  endtask

  task automatic t_prescale;
    logic [DW-1:0] v;
    wr(A_CTRL, 1); wr(A_CNT, 10); wr(A_SCL, 2);
    wr(A_CTRL, 3);
    rd(A_CNT, v); check("R5 start", v, 10);
    step(2); rd(A_CNT, v); check("R5 before first tick", v, 10);
    step(1); rd(A_CNT, v); check("R5 first tick", v, 9);
    step(2); rd(A_CNT, v); check("R5 before second tick", v, 9);
    step(1); rd(A_CNT, v); check("R5 second tick", v, 8);
    wr(A_CTRL, 1);
    rd(A_CNT, v); check("R5 paused", v, 8);
    step(3);
    wr(A_CTRL, 3);
    step(2); rd(A_CNT, v); check("R5 restart no early tick", v, 8);
    step(1); rd(A_CNT, v); check("R5 restart tick", v, 7);
    wr(A_CTRL, 0);
  endtask

  task automatic t_gate_stop;
    logic [DW-1:0] v;
    wr(A_CNT, 7); wr(A_SCL, 0);
    wr(A_CTRL, 1); step(6);
    rd(A_CNT, v); check("R4 power only holds", v, 7);
    wr(A_CTRL, 2); step(6);
    rd(A_CNT, v); check("R4 enable only holds", v, 7);
    wr(A_CTRL, 3);
    rd(A_CNT, v); check("R4 both start", v, 7);
    step(3);
    wr(A_CTRL, 0);
    rd(A_CNT, v); check("R10 stop value", v, 2);
    step(6); rd(A_CNT, v); check("R10 stays stopped", v, 2);
  endtask

  task automatic t_write_wins;
    logic [DW-1:0] v;
    wr(A_CNT, 100); wr(A_SCL, 0);
    wr(A_CTRL, 3);
    step(2); rd(A_CNT, v); check("R11 running", v, 98);
    wr(A_CNT, 40);
    rd(A_CNT, v); check("R11 write beats tick", v, 40);
    step(1); rd(A_CNT, v); check("R11 counts from written", v, 39);
    wr(A_CTRL, 0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_map();
    t_oneshot();
    t_reload();
    t_prescale();
    t_gate_stop();
    t_write_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule